// File: doc/BRIEF.md
# Stop-Mode Clock Controller

This block decides when a processor's clock is frozen and when it starts again. A one-cycle stop request from the CPU moves it from RUN into STOP. In STOP the clock is held and the oscillator is switched off. A wake pin, which arrives asynchronously, ends STOP. The block then goes through WARMUP, with the oscillator on but the clock still held, and through an optional CPUWAIT, with the clock running but the CPU still held. After that it returns to RUN and sends the CPU a one-cycle acknowledge.

Software picks one of two wake policies. In the edge policy only a rising edge on the wake pin ends STOP. In the level policy a high wake pin ends STOP, and a request made while the pin is already high is refused. A change from the edge policy to the level policy waits for the next rising edge on the pin before it takes effect. A change back to the edge policy takes effect at once.

The warm-up length is one of four tick counts, chosen by a 2-bit select. The extra wait is a fixed tick count. Both are timed by a down counter that advances only on a free-running tick.

States and transitions:
- RUN→STOP: on a request, unless the level policy is in effect and the pin is high.
- STOP→WARMUP: on the release condition of the policy in effect.
- WARMUP→CPUWAIT: when the warm-up count ends with the wait enable set.
- WARMUP→RUN: when the warm-up count ends with the wait enable clear.
- CPUWAIT→RUN: when the wait count ends.

Top module: `lp_stop_ctrl`

## Requirements
- R1: After synchronous active-low reset the block is in RUN: cpu_run=1, osc_en=1, clk_halt=0, wake_ack=0, and the edge policy is in effect.
- R2: With the edge policy in effect (rel_level=0 selects it), a stop request enters STOP even when wake_pin is high. STOP then ends only on a low-to-high change of wake_pin, seen after a two-flop synchronizer. A steady high or a steady low keeps the block in STOP.
- R3: With the level policy in effect, a stop request while the synchronized wake_pin is high is refused and the block stays in RUN.
- R4: With the level policy in effect, STOP ends as soon as the synchronized wake_pin is high.
- R5: Every release passes through WARMUP (clk_halt=1, osc_en=1, cpu_run=0). WARMUP lasts warm_sel-selected ticks plus one cycle, with 0→16, 1→32, 2→64 and 3→128 ticks. The count does not advance in cycles where tick=0.
- R6: With xwait_en=1, WARMUP is followed by CPUWAIT (clk_halt=0, osc_en=1, cpu_run=0), which lasts 256 ticks plus one cycle. With xwait_en=0, CPUWAIT is skipped.
- R7: Once WARMUP has begun, a low wake_pin does not bring the block back to STOP.
- R8: Setting rel_level=1 puts the level policy into effect only after the next rising edge of the synchronized wake_pin. Until then the edge policy still applies.
- R9: wake_ack is high for exactly one cycle, the first RUN cycle after a release. A refused request produces no wake_ack.
- R10: In STOP, clk_halt=1, osc_en=0 and cpu_run=0.
- R11: Clearing rel_level returns the block to the edge policy in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Free-running timing tick enable |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| rel_level | input | 1 | Policy select: 1 = level, 0 = edge |
| wake_pin | input | 1 | Asynchronous wake input |
| xwait_en | input | 1 | Adds CPUWAIT after warm-up |
| warm_sel | input | 2 | Warm-up tick count select |
| clk_halt | output | 1 | Holds the system clock |
| osc_en | output | 1 | Oscillator enable |
| cpu_run | output | 1 | CPU may execute |
| wake_ack | output | 1 | One-cycle pulse on return to RUN |

## Verification
A rising edge on the wake pin does two jobs in the same cycle. It releases STOP, and it completes a pending switch to the level policy. The bench provokes this case by setting rel_level while the pin is already high, issuing a request, and then raising the pin while the block is in STOP. It judges the result by requiring that the request is accepted, that exactly one acknowledge arrives on the way back, and that the very next request made with the pin high is refused. Random rounds also mix policy changes, pin changes and sparse ticks, and compare each accept or refuse decision with a bench model of the policy in effect.

// File: rtl/stopctl_pkg.sv
`timescale 1ns/1ps
package stopctl_pkg;
    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_STOP    = 2'd1,
        PH_WARMUP  = 2'd2,
        PH_CPUWAIT = 2'd3
    } phase_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/stopctl_wake_sync.sv
`timescale 1ns/1ps
module stopctl_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_hi,
    output logic pin_rise
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            prev_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], pin_async};
            prev_q <= chain[STAGES-1];
        end
    end

    assign pin_hi   = chain[STAGES-1];
    assign pin_rise = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stopctl_mode_track.sv
`timescale 1ns/1ps
module stopctl_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_level,
    input  logic pin_rise,
    output logic eff_level
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_level <= 1'b0;
        else if (!rel_level)
            eff_level <= 1'b0;
        else if (pin_rise)
            eff_level <= 1'b1;
    end

    // R8
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eff_level) |-> ($past(pin_rise) && $past(rel_level)));

    // R11
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_level |=> !eff_level);
endmodule

// File: rtl/stopctl_tick_timer.sv
`timescale 1ns/1ps
module stopctl_tick_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/lp_stop_ctrl.sv
`timescale 1ns/1ps
module lp_stop_ctrl
    import stopctl_pkg::*;
#(
    parameter int WARM_T0     = 16,
    parameter int WARM_T1     = 32,
    parameter int WARM_T2     = 64,
    parameter int WARM_T3     = 128,
    parameter int XWAIT_TICKS = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       stop_req,
    input  logic       rel_level,
    input  logic       wake_pin,
    input  logic       xwait_en,
    input  logic [1:0] warm_sel,
    output logic       clk_halt,
    output logic       osc_en,
    output logic       cpu_run,
    output logic       wake_ack
);
    localparam int MAX_CNT = imax(imax(imax(WARM_T0, WARM_T1), imax(WARM_T2, WARM_T3)), XWAIT_TICKS);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    phase_t           state, nxt;
    logic             pin_hi, pin_rise, eff_level;
    logic             tm_load, tm_done;
    logic [CNT_W-1:0] tm_val, warm_cnt;
    logic             ack_q;
    logic             release_now;

    stopctl_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(wake_pin),
        .pin_hi   (pin_hi),
        .pin_rise (pin_rise)
    );

    stopctl_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .rel_level(rel_level),
        .pin_rise (pin_rise),
        .eff_level(eff_level)
    );

    stopctl_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (tm_load),
        .load_val(tm_val),
        .done    (tm_done)
    );

    always_comb begin
        unique case (warm_sel)
            2'd0:    warm_cnt = CNT_W'(WARM_T0);
            2'd1:    warm_cnt = CNT_W'(WARM_T1);
            2'd2:    warm_cnt = CNT_W'(WARM_T2);
            default: warm_cnt = CNT_W'(WARM_T3);
        endcase
    end

    assign release_now = eff_level ? pin_hi : pin_rise;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PH_RUN;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = state;
        tm_load = 1'b0;
        tm_val  = warm_cnt;
        unique case (state)
            PH_RUN: begin
                if (stop_req && !(eff_level && pin_hi))
                    nxt = PH_STOP;
            end
            PH_STOP: begin
                if (release_now) begin
                    nxt     = PH_WARMUP;
                    tm_load = 1'b1;
                    tm_val  = warm_cnt;
                end
            end
            PH_WARMUP: begin
                if (tm_done) begin
                    if (xwait_en) begin
                        nxt     = PH_CPUWAIT;
                        tm_load = 1'b1;
                        tm_val  = CNT_W'(XWAIT_TICKS);
                    end else begin
                        nxt = PH_RUN;
                    end
                end
            end
            PH_CPUWAIT: begin
                if (tm_done)
                    nxt = PH_RUN;
            end
            default: nxt = PH_RUN;
        endcase
    end

    // acknowledge pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= (state != PH_RUN) && (nxt == PH_RUN);
    end

    // outputs
    always_comb begin
        clk_halt = 1'b0;
        osc_en   = 1'b1;
        cpu_run  = 1'b0;
        unique case (state)
            PH_RUN:     cpu_run = 1'b1;
            PH_STOP: begin
                clk_halt = 1'b1;
                osc_en   = 1'b0;
            end
            PH_WARMUP:  clk_halt = 1'b1;
            PH_CPUWAIT: clk_halt = 1'b0;
            default:    cpu_run = 1'b1;
        endcase
    end

    assign wake_ack = ack_q;

    // R3
    level_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RUN && stop_req && eff_level && pin_hi) |=> (state == PH_RUN));

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_STOP && !eff_level && !pin_rise) |=> (state == PH_STOP));

    // R6
    cpuwait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CPUWAIT && $past(state) == PH_WARMUP) |-> $past(xwait_en));

    // R7
    warm_no_restop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WARMUP) |=> (state != PH_STOP));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> !wake_ack);

    // R9
    ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |-> (cpu_run && $past(state) != PH_RUN));
endmodule

// File: tb/lp_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_stop_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       stop_req = 1'b0;
    logic       rel_level = 1'b0;
    logic       wake_pin = 1'b0;
    logic       xwait_en = 1'b0;
    logic [1:0] warm_sel = 2'd0;
    logic       clk_halt, osc_en, cpu_run, wake_ack;

    logic tick_force = 1'b1;
    logic rnd_tick   = 1'b0;
    logic rnd_bit    = 1'b1;
    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;
    bit   eff_m = 0;

    assign tick = rnd_tick ? rnd_bit : tick_force;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #5 rnd_bit = (($urandom % 4) != 0);
    end

    lp_stop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop_req(stop_req),
        .rel_level(rel_level), .wake_pin(wake_pin), .xwait_en(xwait_en),
        .warm_sel(warm_sel), .clk_halt(clk_halt), .osc_en(osc_en),
        .cpu_run(cpu_run), .wake_ack(wake_ack)
    );

    function automatic int warm_ticks(input logic [1:0] sel);
        case (sel)
            2'd0: return 16;
            2'd1: return 32;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    function automatic bit expect_enter(input bit eff, input bit pin);
        return !(eff && pin);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1;
        cyc(1);
        stop_req = 1'b0;
    endtask

    // counts phases until RUN returns
    task automatic measure(output int w, output int c, output int s, output int a, output int back);
        w = 0; c = 0; s = 0; a = 0; back = 0;
        for (int i = 0; i < 4000; i++) begin
            cyc(1);
            if (clk_halt && osc_en) w++;
            else if (clk_halt && !osc_en) s++;
            else if (!clk_halt && !cpu_run) c++;
            if (wake_ack) a++;
            if (cpu_run) begin
                back = 1;
                break;
            end
        end
    endtask

    initial begin
        int w, c, s, a, back, entered;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1
        check("R1", "cpu_run", cpu_run, 1);
        check("R1", "osc_en", osc_en, 1);
        check("R1", "clk_halt", clk_halt, 0);
        check("R1", "wake_ack", wake_ack, 0);

        // R2, R10: edge policy enters with pin high
        wake_pin = 1'b1; cyc(6);
        pulse_stop();
        check("R10", "clk_halt in STOP", clk_halt, 1);
        check("R10", "osc_en in STOP", osc_en, 0);
        check("R10", "cpu_run in STOP", cpu_run, 0);
        cyc(20);
        check("R2", "steady high keeps STOP", clk_halt && !osc_en, 1);
        wake_pin = 1'b0; cyc(6);
        check("R2", "falling keeps STOP", clk_halt && !osc_en, 1);
        wake_pin = 1'b1;
        measure(w, c, s, a, back);
        check("R5", "warm cycles sel0", w, 17);
        check("R6", "no cpuwait", c, 0);
        check("R9", "ack count", a, 1);
        cyc(1);
        check("R9", "ack one cycle", wake_ack, 0);

        // R5, R6: longer warm-up plus extra wait
        warm_sel = 2'd2; xwait_en = 1'b1;
        pulse_stop();
        wake_pin = 1'b0; cyc(4);
        wake_pin = 1'b1;
        measure(w, c, s, a, back);
        check("R5", "warm cycles sel2", w, 65);
        check("R6", "cpuwait cycles", c, 257);
        check("R9", "ack count xwait", a, 1);

        // R5: no advance without tick
        warm_sel = 2'd1; xwait_en = 1'b0;
        pulse_stop();
        wake_pin = 1'b0; cyc(4);
        tick_force = 1'b0;
        wake_pin = 1'b1; cyc(40);
        check("R5", "held in warmup without tick", clk_halt && osc_en && !cpu_run, 1);
        tick_force = 1'b1;
        measure(w, c, s, a, back);
        check("R5", "remaining warm cycles", w, 32);

        // R8: deferred switch; release and switch in same cycle
        rel_level = 1'b1; cyc(4);
        pulse_stop();
        check("R8", "still edge policy, entered", clk_halt && !osc_en, 1);
        wake_pin = 1'b0; cyc(4);
        wake_pin = 1'b1;
        measure(w, c, s, a, back);
        check("R8", "released by rise", back, 1);
        check("R9", "ack after rise", a, 1);
        pulse_stop();
        a = 0;
        for (int i = 0; i < 4; i++) begin
            if (wake_ack) a++;
            if (!cpu_run || clk_halt) a += 100;
            cyc(1);
        end
        check("R3", "refused with pin high", a, 0);
        eff_m = 1;

        // R4, R7
        wake_pin = 1'b0; cyc(4);
        pulse_stop();
        cyc(5);
        check("R4", "entered with pin low", clk_halt && !osc_en, 1);
        wake_pin = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (clk_halt && osc_en) break;
            cyc(1);
        end
        check("R4", "warmup reached on level", clk_halt && osc_en, 1);
        wake_pin = 1'b0;
        measure(w, c, s, a, back);
        check("R7", "no return to STOP", s, 0);
        check("R7", "back to RUN", back, 1);

        // R11: back to edge policy at once
        rel_level = 1'b0; cyc(2);
        wake_pin = 1'b1; cyc(4);
        pulse_stop();
        check("R11", "edge entry with pin high", clk_halt && !osc_en, 1);
        wake_pin = 1'b0; cyc(4);
        wake_pin = 1'b1;
        measure(w, c, s, a, back);
        check("R11", "released", back, 1);
        eff_m = 0;

        // random rounds
        rnd_tick = 1'b1;
        for (int it = 0; it < 40; it++) begin
            bit nrel, npin;
            nrel = bit'($urandom % 2);
            rel_level = nrel;
            if (!nrel) eff_m = 0;
            cyc(2);
            npin = bit'($urandom % 2);
            if (npin && !wake_pin && nrel) eff_m = 1;
            wake_pin = npin;
            cyc(4);
            warm_sel = 2'($urandom % 4);
            xwait_en = (($urandom % 4) == 0);
            pulse_stop();
            cyc(3);
            entered = (clk_halt && !cpu_run) ? 1 : 0;
            check(eff_m ? "R3" : "R2", "random entry decision", entered,
                  int'(expect_enter(eff_m, wake_pin)));
            if (entered != 0) begin
                if (eff_m) begin
                    wake_pin = 1'b1;
                end else begin
                    if (wake_pin) begin
                        wake_pin = 1'b0; cyc(4);
                    end
                    wake_pin = 1'b1;
                    if (rel_level) eff_m = 1;
                end
                measure(w, c, s, a, back);
                check("R9", "random ack", a, 1);
                check("R6", "random cpuwait presence", (c > 0) ? 1 : 0, int'(xwait_en));
                check("R4", "random return", back, 1);
            end else begin
                a = 0;
                for (int i = 0; i < 3; i++) begin
                    if (wake_ack) a++;
                    cyc(1);
                end
                check("R9", "no ack on refusal", a, 0);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule